// File: doc/BRIEF.md
# SPI Flash Boot Power Sequencer

This block is the bus master that a device uses toward its serial flash PROM while it boots. It stays quiet while reset is held low. On the first clock after reset is released, it samples a strap input. A low strap means another agent owns the flash bus, so the block stays off the bus until the next reset. A high strap makes it the master.

As master, the block selects the flash and shifts out the wake-up command 0xAB. It then deselects the flash and waits a timed idle gap of at least 10 µs. After the gap it releases the bus and starts a downstream read engine with a one-cycle pulse. When the engine reports that configuration is complete, the block checks a power-down enable. If the enable is high, it shifts out the sleep command 0xB9 and waits a second gap. Either way, it then signals completion with a one-cycle pulse and goes idle.

The gap length is fixed at elaboration from a clock-frequency parameter and is rounded up to whole clocks. The serial clock runs at the system clock divided by twice `SCK_HALF`.

Top module: `flash_boot_seq`

## Requirements
- R1: While `rstN` is low, `spiOe` is 0, `spiSsN` is 1, `spiSck` and `spiMosi` are 0, and neither `readStart` nor `seqDone` is asserted.
- R2: `modeSel` is sampled once, on the first rising edge at which `rstN` is high. If it is 0, `spiOe`, `readStart` and `seqDone` stay 0 and the SPI outputs stay idle until the next reset, whatever `modeSel` and `cfgDone` do later.
- R3: If `modeSel` is 1, the clock cycle after that edge begins the wake command. `spiSsN` is 0 and `spiOe` is 1 for 16·`SCK_HALF` cycles. `spiSck` starts low and is high in every odd half-period of `SCK_HALF` cycles. `spiMosi` carries 0xAB most-significant bit first, with bit 7 present before the first rising edge of `spiSck`.
- R4: `spiMosi` changes only together with a falling edge of `spiSck`, or when select goes low. It never changes at a rising edge.
- R5: `spiSsN` rises in the cycle of the last falling edge of `spiSck`. It then stays high, with `spiOe` 1 and `spiSck` low, for ceil(`CLK_HZ`·`GAP_NS`/10⁹) cycles. This is the minimum idle time between commands.
- R6: After the wake gap, `readStart` is 1 for exactly one cycle. From that cycle on, `spiOe` is 0 until configuration completes.
- R7: `cfgDone` is ignored in every state except waiting for the read engine.
- R8: If `cfgDone` is sampled high with `pwrDownEn` 1, the next cycle starts the command 0xB9, framed as in R3 to R5. `seqDone` pulses for one cycle right after its gap.
- R9: If `cfgDone` is sampled high with `pwrDownEn` 0, `seqDone` pulses in the next cycle and no command is sent.
- R10: After `seqDone`, all outputs stay idle (`spiOe` 0) until reset, and `seqDone` does not pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low; hold low until the flash has powered up |
| modeSel | input | 1 | Strap: 1 = act as bus master, 0 = stay off the bus |
| pwrDownEn | input | 1 | 1 = send the sleep command after configuration |
| cfgDone | input | 1 | Read engine reports configuration complete |
| spiSck | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the flash |
| spiSsN | output | 1 | Flash select, active low |
| spiOe | output | 1 | Output enable for the three SPI outputs |
| readStart | output | 1 | One-cycle start pulse to the read engine |
| seqDone | output | 1 | One-cycle completion pulse |

## Verification
A wrong bit position or divider count shows up as a wrong `spiMosi` or `spiSck` value within one half-period of serial clock. A wrong state shows up at once as select, output enable or a pulse appearing in the wrong cycle. A gap counter that ends early or late moves the `readStart` or `seqDone` pulse by at least one cycle, so it is seen at the end of the gap. A strap or done state that fails to hold shows up as bus activity long after the point where the bus should have gone silent. For that reason the idle stretches after such a point are compared cycle by cycle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  localparam logic [7:0] CMD_WAKE  = 8'hAB;
  localparam logic [7:0] CMD_SLEEP = 8'hB9;

  typedef enum logic [2:0] {
    ST_STRAP,
    ST_SLAVE,
    ST_SHIFT,
    ST_GAP,
    ST_HAND,
    ST_WAIT,
    ST_DONE,
    ST_FIN
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // load a new command into the shifter
    logic cmdSleep;  // on load: 1 = sleep command, 0 = wake command
    logic shiftRun;  // serial frame in progress
    logic gapRun;    // idle gap in progress
  } strobeT;

endpackage

// File: rtl/fbs_datapath.sv
module fbs_datapath #(
  parameter int SCK_HALF = 2,
  parameter int GAP_CYC  = 1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  fbs_pkg::strobeT strb,
  output logic            shiftLast,
  output logic            gapLast,
  output logic            spiSck,
  output logic            spiMosi,
  output logic            spiSsN,
  output logic            spiOe
);
  import fbs_pkg::*;

  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [DW-1:0] DivTop = DW'(SCK_HALF - 1);
  localparam logic [GW-1:0] GapTop = GW'(GAP_CYC - 1);

  logic [DW-1:0] divCnt;
  logic [3:0]    halfCnt;
  logic [7:0]    shReg;
  logic [GW-1:0] gapCnt;
  logic          divWrap;

  assign divWrap = (divCnt == DivTop);

  // shifter and serial clock divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      halfCnt <= '0;
      shReg   <= '0;
    end else if (strb.load) begin
      divCnt  <= '0;
      halfCnt <= '0;
      shReg   <= strb.cmdSleep ? CMD_SLEEP : CMD_WAKE;
    end else if (strb.shiftRun) begin
      if (divWrap) begin
        divCnt  <= '0;
        halfCnt <= halfCnt + 4'd1;
        if (halfCnt[0]) shReg <= {shReg[6:0], 1'b0};  // advance on falling edge
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // inter-command gap timer
  always_ff @(posedge clk) begin
    if (!rstN)             gapCnt <= '0;
    else if (strb.gapRun)  gapCnt <= gapCnt + 1'b1;
    else                   gapCnt <= '0;
  end

  assign shiftLast = strb.shiftRun && divWrap && (halfCnt == 4'd15);
  assign gapLast   = strb.gapRun && (gapCnt == GapTop);

  assign spiSck  = strb.shiftRun & halfCnt[0];
  assign spiMosi = strb.shiftRun & shReg[7];
  assign spiSsN  = ~strb.shiftRun;
  assign spiOe   = strb.shiftRun | strb.gapRun;

  // data is never updated under a rising serial clock edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftRun && $past(strb.shiftRun) && spiSck && !$past(spiSck))
      |-> (spiMosi == $past(spiMosi)));

  // half-period index only moves forward inside a frame
  p_half_fwd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftRun && $past(strb.shiftRun) && !$past(strb.load))
      |-> (halfCnt >= $past(halfCnt)));

endmodule

// File: rtl/fbs_control.sv
module fbs_control (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeSel,
  input  logic            pwrDownEn,
  input  logic            cfgDone,
  input  logic            shiftLast,
  input  logic            gapLast,
  output fbs_pkg::strobeT strb,
  output logic            readStart,
  output logic            seqDone
);
  import fbs_pkg::*;

  seqStateT state, stateNxt;
  logic     sleepPh, sleepPhNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_STRAP;
      sleepPh <= 1'b0;
    end else begin
      state   <= stateNxt;
      sleepPh <= sleepPhNxt;
    end
  end

  always_comb begin
    stateNxt   = state;
    sleepPhNxt = sleepPh;
    strb       = '0;
    unique case (state)
      ST_STRAP: begin
        if (modeSel) begin
          strb.load  = 1'b1;
          sleepPhNxt = 1'b0;
          stateNxt   = ST_SHIFT;
        end else begin
          stateNxt = ST_SLAVE;
        end
      end
      ST_SLAVE: stateNxt = ST_SLAVE;
      ST_SHIFT: begin
        strb.shiftRun = 1'b1;
        if (shiftLast) stateNxt = ST_GAP;
      end
      ST_GAP: begin
        strb.gapRun = 1'b1;
        if (gapLast) stateNxt = sleepPh ? ST_DONE : ST_HAND;
      end
      ST_HAND: stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (cfgDone) begin
          if (pwrDownEn) begin
            strb.load     = 1'b1;
            strb.cmdSleep = 1'b1;
            sleepPhNxt    = 1'b1;
            stateNxt      = ST_SHIFT;
          end else begin
            stateNxt = ST_DONE;
          end
        end
      end
      ST_DONE: stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_FIN;
      default: stateNxt = ST_STRAP;
    endcase
  end

  assign readStart = (state == ST_HAND);
  assign seqDone   = (state == ST_DONE);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    readStart |=> (!readStart && !strb.shiftRun && !strb.gapRun));

  p_done_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(seqDone) |-> (!seqDone && state == ST_FIN));

  p_slave_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_SLAVE) && $past(rstN)) |-> (state == ST_SLAVE && strb == '0));

endmodule

// File: rtl/flash_boot_seq.sv
module flash_boot_seq #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int GAP_NS   = 10_000,
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeSel,
  input  logic pwrDownEn,
  input  logic cfgDone,
  output logic spiSck,
  output logic spiMosi,
  output logic spiSsN,
  output logic spiOe,
  output logic readStart,
  output logic seqDone
);
  import fbs_pkg::*;

  localparam longint GapProd = longint'(CLK_HZ) * longint'(GAP_NS);
  localparam longint GapRaw  = (GapProd + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int     GAP_CYC = (GapRaw < 1) ? 1 : int'(GapRaw);

  strobeT strb;
  logic   shiftLast, gapLast;

  fbs_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .pwrDownEn (pwrDownEn),
    .cfgDone   (cfgDone),
    .shiftLast (shiftLast),
    .gapLast   (gapLast),
    .strb      (strb),
    .readStart (readStart),
    .seqDone   (seqDone)
  );

  fbs_datapath #(
    .SCK_HALF (SCK_HALF),
    .GAP_CYC  (GAP_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .shiftLast (shiftLast),
    .gapLast   (gapLast),
    .spiSck    (spiSck),
    .spiMosi   (spiMosi),
    .spiSsN    (spiSsN),
    .spiOe     (spiOe)
  );

  // deselect always opens a driven, clock-low gap
  p_ss_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSsN) |-> (spiOe && !spiSck && !readStart && !seqDone));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({spiOe, readStart, seqDone}));

endmodule

// File: tb/flash_boot_seq_bench.sv
module flash_boot_seq_bench;

  localparam int CLK_HZ   = 12_345_678;
  localparam int GAP_NS   = 10_000;
  localparam int SCK_HALF = 2;
  localparam longint PROD = longint'(CLK_HZ) * longint'(GAP_NS);
  localparam int GAP = int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);

  typedef struct {
    bit oe; bit ssN; bit sck; bit mosi; bit rs; bit dn;
    string tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b1;
  logic pwrDownEn = 1'b1;
  logic cfgDone = 1'b0;
  logic spiSck, spiMosi, spiSsN, spiOe, readStart, seqDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  expT q[$];

  always #5 clk = ~clk;

  flash_boot_seq #(.CLK_HZ(CLK_HZ), .GAP_NS(GAP_NS), .SCK_HALF(SCK_HALF)) u_flash_boot_seq (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .pwrDownEn(pwrDownEn),
    .cfgDone(cfgDone), .spiSck(spiSck), .spiMosi(spiMosi), .spiSsN(spiSsN),
    .spiOe(spiOe), .readStart(readStart), .seqDone(seqDone)
  );

  function automatic expT mk(bit oe, bit ssN, bit sck, bit mosi, bit rs, bit dn, string tag);
    expT e;
    e.oe = oe; e.ssN = ssN; e.sck = sck; e.mosi = mosi; e.rs = rs; e.dn = dn; e.tag = tag;
    return e;
  endfunction

  task automatic pushIdle(int n, string tag);
    for (int i = 0; i < n; i++) q.push_back(mk(0, 1, 0, 0, 0, 0, tag));
  endtask

  task automatic pushCmd(logic [7:0] cmd, string tag);
    for (int k = 0; k < 16 * SCK_HALF; k++) begin
      int half = k / SCK_HALF;
      q.push_back(mk(1, 0, bit'(half % 2), cmd[7 - half / 2], 0, 0, tag));
    end
  endtask

  task automatic pushGap(string tag);
    for (int i = 0; i < GAP; i++) q.push_back(mk(1, 1, 0, 0, 0, 0, tag));
  endtask

  task automatic step();
    expT e;
    @(negedge clk);
    e = q.pop_front();
    nChecks++;
    if (spiOe !== e.oe || spiSsN !== e.ssN || spiSck !== e.sck || spiMosi !== e.mosi ||
        readStart !== e.rs || seqDone !== e.dn) begin
      nFails++;
      $display("FAIL %s: got oe=%b ss=%b sck=%b mosi=%b rs=%b dn=%b exp oe=%b ss=%b sck=%b mosi=%b rs=%b dn=%b",
               e.tag, spiOe, spiSsN, spiSck, spiMosi, readStart, seqDone,
               e.oe, e.ssN, e.sck, e.mosi, e.rs, e.dn);
    end
  endtask

  task automatic runAll();
    while (q.size() > 0) step();
  endtask

  // master boot up to waiting for the read engine (R3, R4, R5, R6, R7)
  task automatic bootMaster();
    rstN = 1'b0; modeSel = 1'b1; cfgDone = 1'b0;
    pushIdle(3, "R1"); runAll();
    rstN = 1'b1;
    cfgDone = 1'b1;  // R7: must be ignored during the wake frame and gap
    pushCmd(8'hAB, "R3,R4"); pushGap("R5,R7");
    q.push_back(mk(0, 1, 0, 0, 1, 0, "R6")); runAll();
    cfgDone = 1'b0;
    pushIdle(6, "R6"); runAll();
  endtask

  initial begin
    // run 1: sleep command enabled
    pwrDownEn = 1'b1;
    bootMaster();
    cfgDone = 1'b1;
    pushCmd(8'hB9, "R8"); step();
    cfgDone = 1'b0;
    pushGap("R8");
    q.push_back(mk(0, 1, 0, 0, 0, 1, "R8"));
    pushIdle(20, "R10"); runAll();
    cfgDone = 1'b1; pwrDownEn = 1'b1;   // late completion must not restart
    pushIdle(30, "R10"); runAll();
    cfgDone = 1'b0;

    // run 2: sleep command disabled
    pwrDownEn = 1'b0;
    bootMaster();
    cfgDone = 1'b1;
    q.push_back(mk(0, 1, 0, 0, 0, 1, "R9")); step();
    cfgDone = 1'b0;
    pushIdle(40, "R9,R10"); runAll();

    // run 3: strap low, block must stay off the bus
    rstN = 1'b0; modeSel = 1'b0;
    pushIdle(3, "R1"); runAll();
    rstN = 1'b1;
    pushIdle(60, "R2"); runAll();
    modeSel = 1'b1; cfgDone = 1'b1; pwrDownEn = 1'b1;
    pushIdle(60, "R2"); runAll();
    cfgDone = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule